// File: doc/BRIEF.md
# Power-Good Status Aggregator

The block folds the health of four supply rails (two switching converters and two linear regulators) and three device-wide conditions into one power-good signal. Each rail reports whether it is switched on and whether its output sits below or above tolerance. The device-wide inputs are a die temperature warning, an input overvoltage event and a thermal shutdown event. Static configuration picks which rails and whether the temperature warning take part, per-rail window checking, output polarity, driver style and whether a failure is held until software acknowledges it.

The combined status is filtered by a consecutive-cycle counter so that short glitches never reach the pin. In continuous operation the pin follows the filtered status. In gated operation, once a filtered failure has been seen, the pin stays deasserted until a clear pulse arrives while every source is valid. The interface is plain level-based control and status; there is no data stream, so no valid/ready handshake or back-pressure applies.

Top module: `pgood_agg`

## Requirements
- R1: A rail whose select bit and enable status are both 1 and whose undervoltage flag is 1 deasserts power-good.
- R2: A rail whose enable status is 0, or whose select bit is 0, has no effect on power-good whatever its flags show.
- R3: With a rail's window bit at 0 its overvoltage flag is ignored; with the bit at 1 an overvoltage flag on a selected, enabled rail deasserts power-good.
- R4: The temperature warning deasserts power-good only while its select bit is 1.
- R5: The input overvoltage and thermal shutdown events each deassert power-good regardless of any select bit.
- R6: With the polarity bit at 1 the asserted level is high; with it at 0 the asserted level is low.
- R7: With the drive bit at 0 (push-pull) the output-enable is always 1 and the pin carries the level; with it at 1 (open-drain) the pin value is 0 and the output-enable is 1 exactly when the level is low.
- R8: A change of the combined status reaches the output only after it has held for FILT_LEN consecutive clock edges; a change lasting FILT_LEN-1 cycles or less is ignored.
- R9: With the mode bit at 0 (continuous) power-good reasserts on its own once the filtered status becomes valid again.
- R10: With the mode bit at 1 (gated) a filtered failure is latched; power-good stays deasserted after the sources recover until a clear pulse is given while the filtered status is valid, and a clear given while a source is still invalid has no effect.
- R11: During and after reset power-good is deasserted until the filtered status first becomes valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rail_on | input | 4 | Per-rail enable status (bits 1:0 converters, 3:2 linear regulators) |
| rail_under | input | 4 | Per-rail undervoltage flag |
| rail_over | input | 4 | Per-rail overvoltage flag |
| rail_pick | input | 4 | Per-rail select for power-good participation |
| rail_window | input | 4 | Per-rail check type: 0 undervoltage only, 1 both limits |
| hot_warn | input | 1 | Die temperature warning status |
| hot_warn_pick | input | 1 | Include the temperature warning |
| vin_over_evt | input | 1 | Input overvoltage event |
| hot_shut_evt | input | 1 | Thermal shutdown event |
| level_high | input | 1 | Polarity: 1 asserted-high, 0 asserted-low |
| drive_od | input | 1 | Driver style: 0 push-pull, 1 open-drain |
| hold_mode | input | 1 | Mode: 0 continuous, 1 gated |
| ack_clear | input | 1 | Clear pulse for the gated latch |
| pg_pin | output | 1 | Pin value |
| pg_oe | output | 1 | Pin output-enable |

## Verification
The assertions take for granted that all flags and configuration bits are synchronous to the clock and that the clear input is a pulse judged together with the filtered status on the same edge. They also assume the filter length is at least two, so a filtered failure cannot both fall and recover before the gated latch sets. The bench changes every input just after a falling edge and holds each pattern for more than FILT_LEN cycles, except in the glitch case, which deliberately holds a failure for exactly FILT_LEN-1 cycles.

// File: rtl/pgood_pkg.sv
package pgood_pkg;
  localparam int unsigned CONV_RAILS = 2;
  localparam int unsigned LIN_RAILS  = 2;
  localparam int unsigned ALL_RAILS  = CONV_RAILS + LIN_RAILS;

  typedef enum logic {
    DRV_PUSHPULL  = 1'b0,
    DRV_OPENDRAIN = 1'b1
  } drive_e;

  typedef enum logic {
    MODE_FOLLOW = 1'b0,
    MODE_HOLD   = 1'b1
  } mode_e;
endpackage

// File: rtl/pg_combine.sv
module pg_combine #(
  parameter int unsigned RAILS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RAILS-1:0] rail_on,
  input  logic [RAILS-1:0] rail_under,
  input  logic [RAILS-1:0] rail_over,
  input  logic [RAILS-1:0] rail_pick,
  input  logic [RAILS-1:0] rail_window,
  input  logic             hot_warn,
  input  logic             hot_warn_pick,
  input  logic             vin_over_evt,
  input  logic             hot_shut_evt,
  output logic             raw_ok
);
  logic [RAILS-1:0] rail_bad;

  for (genvar g = 0; g < RAILS; g++) begin : g_rail
    logic out_of_tol;
    assign out_of_tol  = rail_under[g] | (rail_window[g] & rail_over[g]);
    assign rail_bad[g] = rail_pick[g] & rail_on[g] & out_of_tol;
  end

  logic dev_bad;
  assign dev_bad = (hot_warn_pick & hot_warn) | vin_over_evt | hot_shut_evt;
  assign raw_ok  = ~(|rail_bad) & ~dev_bad;

  AST_IDLE_RAILS_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (((rail_on & rail_pick) == '0) && !vin_over_evt && !hot_shut_evt && !(hot_warn && hot_warn_pick)) |-> raw_ok); // R2
  AST_DEV_FAULT_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (vin_over_evt || hot_shut_evt) |-> !raw_ok); // R5
  AST_UNDER_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    ((rail_on & rail_pick & rail_under) != '0) |-> !raw_ok); // R1
endmodule

// File: rtl/pg_filter.sv
module pg_filter #(
  parameter int unsigned FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_ok,
  output logic filt_ok,
  output logic filt_fall
);
  localparam int unsigned CW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic [CW-1:0] run_q;
  logic          flip;

  assign flip = (raw_ok != filt_ok) && (run_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_ok   <= 1'b0;
      run_q     <= '0;
      filt_fall <= 1'b0;
    end else begin
      filt_fall <= flip & filt_ok;
      if (raw_ok == filt_ok) begin
        run_q <= '0;
      end else if (flip) begin
        filt_ok <= raw_ok;
        run_q   <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  AST_FILT_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_ok != $past(filt_ok)) |-> ($past(run_q) == LAST)); // R8
  AST_FILT_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_ok != $past(filt_ok)) |-> (filt_ok == $past(raw_ok))); // R8
endmodule

// File: rtl/pg_drive.sv
module pg_drive
  import pgood_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic filt_ok,
  input  logic filt_fall,
  input  logic hold_mode,
  input  logic ack_clear,
  input  logic level_high,
  input  logic drive_od,
  output logic pg_pin,
  output logic pg_oe
);
  logic  trip_q;
  logic  good;
  logic  level;
  mode_e mode;
  drive_e drv;

  assign mode = mode_e'(hold_mode);
  assign drv  = drive_e'(drive_od);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       trip_q <= 1'b0;
    else if (mode == MODE_FOLLOW)     trip_q <= 1'b0;
    else if (filt_fall)               trip_q <= 1'b1;
    else if (ack_clear && filt_ok)    trip_q <= 1'b0;
  end

  assign good  = filt_ok & ~trip_q;
  assign level = good ? level_high : ~level_high;

  always_comb begin
    if (drv == DRV_OPENDRAIN) begin
      pg_pin = 1'b0;
      pg_oe  = ~level;
    end else begin
      pg_pin = level;
      pg_oe  = 1'b1;
    end
  end

  AST_PP_ALWAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_od |-> pg_oe); // R7
  AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    drive_od |-> !pg_pin); // R7
  AST_HOLD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_mode && trip_q && !ack_clear) |=> trip_q); // R10
  AST_CLEAR_NEEDS_OK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trip_q) |-> (!$past(hold_mode) || ($past(ack_clear) && $past(filt_ok)))); // R10
endmodule

// File: rtl/pgood_agg.sv
module pgood_agg
  import pgood_pkg::*;
#(
  parameter int unsigned FILT_LEN = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ALL_RAILS-1:0] rail_on,
  input  logic [ALL_RAILS-1:0] rail_under,
  input  logic [ALL_RAILS-1:0] rail_over,
  input  logic [ALL_RAILS-1:0] rail_pick,
  input  logic [ALL_RAILS-1:0] rail_window,
  input  logic                 hot_warn,
  input  logic                 hot_warn_pick,
  input  logic                 vin_over_evt,
  input  logic                 hot_shut_evt,
  input  logic                 level_high,
  input  logic                 drive_od,
  input  logic                 hold_mode,
  input  logic                 ack_clear,
  output logic                 pg_pin,
  output logic                 pg_oe
);
  logic raw_ok;
  logic filt_ok;
  logic filt_fall;

  pg_combine #(.RAILS(ALL_RAILS)) u_combine (
    .clk(clk), .rst_n(rst_n),
    .rail_on(rail_on), .rail_under(rail_under), .rail_over(rail_over),
    .rail_pick(rail_pick), .rail_window(rail_window),
    .hot_warn(hot_warn), .hot_warn_pick(hot_warn_pick),
    .vin_over_evt(vin_over_evt), .hot_shut_evt(hot_shut_evt),
    .raw_ok(raw_ok)
  );

  pg_filter #(.FILT_LEN(FILT_LEN)) u_filter (
    .clk(clk), .rst_n(rst_n), .raw_ok(raw_ok),
    .filt_ok(filt_ok), .filt_fall(filt_fall)
  );

  pg_drive u_drive (
    .clk(clk), .rst_n(rst_n),
    .filt_ok(filt_ok), .filt_fall(filt_fall),
    .hold_mode(hold_mode), .ack_clear(ack_clear),
    .level_high(level_high), .drive_od(drive_od),
    .pg_pin(pg_pin), .pg_oe(pg_oe)
  );

  AST_ASSERT_NEEDS_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (!drive_od && (pg_pin == level_high)) |-> filt_ok); // R11
endmodule

// File: tb/pgood_agg_bench.sv
module pgood_agg_bench;
  localparam int unsigned FL = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] rail_on, rail_under, rail_over, rail_pick, rail_window;
  logic       hot_warn, hot_warn_pick, vin_over_evt, hot_shut_evt;
  logic       level_high, drive_od, hold_mode, ack_clear;
  logic       pg_pin, pg_oe;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  pgood_agg #(.FILT_LEN(FL)) u_pgood_agg (
    .clk(clk), .rst_n(rst_n),
    .rail_on(rail_on), .rail_under(rail_under), .rail_over(rail_over),
    .rail_pick(rail_pick), .rail_window(rail_window),
    .hot_warn(hot_warn), .hot_warn_pick(hot_warn_pick),
    .vin_over_evt(vin_over_evt), .hot_shut_evt(hot_shut_evt),
    .level_high(level_high), .drive_od(drive_od),
    .hold_mode(hold_mode), .ack_clear(ack_clear),
    .pg_pin(pg_pin), .pg_oe(pg_oe)
  );

  // Line level as seen with an external pull-up in open-drain style.
  function automatic logic line_level();
    return drive_od ? (pg_oe ? 1'b0 : 1'b1) : pg_pin;
  endfunction

  function automatic logic asserted();
    return line_level() == level_high;
  endfunction

  task automatic check(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (FL + 2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic defaults();
    rail_on = '1; rail_under = '0; rail_over = '0; rail_pick = '1; rail_window = '1;
    hot_warn = 0; hot_warn_pick = 1; vin_over_evt = 0; hot_shut_evt = 0;
    level_high = 1; drive_od = 0; hold_mode = 0; ack_clear = 0;
  endtask

  task automatic t_reset();
    defaults();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R11 during reset", asserted(), 1'b0);
    rst_n = 1;
    @(negedge clk);
    check("R11 just after reset", asserted(), 1'b0);
    settle();
    check("R11 first valid", asserted(), 1'b1);
  endtask

  task automatic t_rail_under();
    rail_under = 4'b0100; settle();
    check("R1 ldo0 under", asserted(), 1'b0);
    rail_under = 4'b0001; settle();
    check("R1 buck0 under", asserted(), 1'b0);
    rail_under = '0; settle();
    check("R1 recovered", asserted(), 1'b1);
  endtask

  task automatic t_masking();
    rail_under = 4'b1000; rail_on = 4'b0111; settle();
    check("R2 disabled rail masked", asserted(), 1'b1);
    rail_on = '1; rail_pick = 4'b0111; settle();
    check("R2 unselected rail masked", asserted(), 1'b1);
    rail_pick = '1; settle();
    check("R2 reselected rail counts", asserted(), 1'b0);
    rail_under = '0; settle();
  endtask

  task automatic t_window();
    rail_window = 4'b1101; rail_over = 4'b0010; settle();
    check("R3 over ignored window=0", asserted(), 1'b1);
    rail_window = '1; settle();
    check("R3 over counts window=1", asserted(), 1'b0);
    rail_over = '0; settle();
  endtask

  task automatic t_warn();
    hot_warn_pick = 0; hot_warn = 1; settle();
    check("R4 warn unselected", asserted(), 1'b1);
    hot_warn_pick = 1; settle();
    check("R4 warn selected", asserted(), 1'b0);
    hot_warn = 0; settle();
  endtask

  task automatic t_faults();
    rail_pick = '0; hot_warn_pick = 0;
    vin_over_evt = 1; settle();
    check("R5 input overvoltage", asserted(), 1'b0);
    vin_over_evt = 0; hot_shut_evt = 1; settle();
    check("R5 thermal shutdown", asserted(), 1'b0);
    hot_shut_evt = 0; settle();
    check("R5 recovered", asserted(), 1'b1);
    rail_pick = '1; hot_warn_pick = 1;
  endtask

  task automatic t_polarity();
    level_high = 0; #1;
    check("R6 active-low good pin", pg_pin, 1'b0);
    rail_under = 4'b0001; settle();
    check("R6 active-low bad pin", pg_pin, 1'b1);
    rail_under = '0; settle();
    level_high = 1; #1;
    check("R6 active-high good pin", pg_pin, 1'b1);
  endtask

  task automatic t_drive();
    check("R7 push-pull oe", pg_oe, 1'b1);
    drive_od = 1; #1;
    check("R7 od released on high", pg_oe, 1'b0);
    check("R7 od pin zero", pg_pin, 1'b0);
    rail_under = 4'b0010; settle();
    check("R7 od drives low", pg_oe, 1'b1);
    rail_under = '0; settle();
    drive_od = 0; #1;
  endtask

  task automatic t_glitch();
    rail_under = 4'b0001;
    repeat (FL - 1) @(negedge clk);
    check("R8 glitch not yet seen", asserted(), 1'b1);
    rail_under = '0; settle();
    check("R8 short glitch ignored", asserted(), 1'b1);
    rail_under = 4'b0001;
    repeat (FL - 1) @(negedge clk);
    check("R8 before FILT_LEN", asserted(), 1'b1);
    @(negedge clk);
    check("R8 at FILT_LEN", asserted(), 1'b0);
    rail_under = '0; settle();
  endtask

  task automatic t_follow();
    hold_mode = 0;
    hot_shut_evt = 1; settle();
    check("R9 follow fails", asserted(), 1'b0);
    hot_shut_evt = 0; settle();
    check("R9 follow recovers", asserted(), 1'b1);
  endtask

  task automatic t_hold();
    hold_mode = 1; settle();
    check("R10 gated idle good", asserted(), 1'b1);
    rail_under = 4'b1000; settle();
    check("R10 gated fails", asserted(), 1'b0);
    ack_clear = 1; @(negedge clk); ack_clear = 0;
    rail_under = '0; settle();
    check("R10 clear while bad ignored", asserted(), 1'b0);
    ack_clear = 1; @(negedge clk); ack_clear = 0;
    check("R10 clear while good", asserted(), 1'b1);
    hold_mode = 0;
  endtask

  initial begin
    t_reset();
    t_rail_under();
    t_masking();
    t_window();
    t_warn();
    t_faults();
    t_polarity();
    t_drive();
    t_glitch();
    t_follow();
    t_hold();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected<=20000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule